// File: doc/BRIEF.md
# Processor exception entry controller

This block sits beside the fetch and decode stages of a small soft-core CPU. It decides whether the processor takes an external interrupt, a hardware break, a hardware exception or a memory-translation fault. When it takes one, it performs every state change that entry involves. Each cycle it samples:

- the current program counter;
- the status register;
- the instruction-state flags: delay slot, immediate prefix, and prefixed branch;
- the pending branch target;
- the cause requests.

When a request is accepted, one clock edge later the block raises a single-cycle `enter` pulse. The same edge presents:

- the vector address to fetch from;
- the rewritten status word;
- a register-file write: the index and value of the return-address register.

The pipeline uses `enter` to flush. It also clears its delay-slot and immediate-prefix flags on that pulse.

For exceptions (hardware or translation fault), the block also keeps three registers: the exception syndrome, the faulting address and the branch target. These are updated only on those entries. The return address is rewound for translation faults, so that an interrupted branch is executed again together with its immediate prefix. Vector addresses are a parameter base plus a fixed offset per cause.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge every output is driven to zero and `enter` is low.
- R2: Requests sampled at an edge produce `enter` high for exactly that following cycle. When several requests are accepted together, the priority is translation fault, then hardware exception, then break, then interrupt. With no accepted request, `enter` is low.
- R3: An interrupt is accepted only when status bit 1 (interrupt enable) is set and status bits 7 (exception in progress) and 2 (break in progress) are clear. `in_dslot` and `in_imm` must also both be low.
- R4: `new_pc` is `VEC_BASE` + 0x10 for an interrupt, + 0x18 for a break, and + 0x20 for a hardware exception or translation fault.
- R5: On every entry, status bit 5 (translation on) is copied into bit 6 and bit 3 (user mode) is copied into bit 4. Bits 5 and 3 are then cleared. All other bits pass through except those named in R6.
- R6: An interrupt entry clears bit 1. A break entry sets bit 2. A hardware exception or translation fault entry sets bit 7.
- R7: `rf_idx`/`rf_data` are 14/PC for an interrupt, 16/PC for a break, and 17/PC+4 for a hardware exception.
- R8: A translation fault writes register 17 with the PC, reduced as follows. In a delay slot it is reduced by 4, or by 8 when `br_imm` is set. Outside a delay slot it is reduced by 4 when `in_imm` is set.
- R9: On a hardware exception or translation fault, syndrome bit 12 equals `in_dslot`. When `in_dslot` is set, `btr` takes `br_target`; otherwise `btr` keeps its value.
- R10: A translation-fault syndrome has code bits [4:0] set as follows:
  - protection fault (`mmu_miss`=0): 17 for a fetch (`mmu_fetch`=1), 16 otherwise;
  - miss (`mmu_miss`=1): 19 for a fetch, 18 otherwise.

  Bit 10 equals `mmu_store`, all other bits except 12 are zero, and `fault_addr` takes `mmu_addr`.
- R11: An unaligned-access hardware exception sets syndrome [4:0] to 1. Bits [11:5] take `unal_det` when `unal_det_vld` is set and are zero otherwise. All other bits except 12 are zero, and `fault_addr` takes `unal_addr`.
- R12: With `HAS_EXC` = 0, `unal_req` has no effect: no entry is taken and `syndrome`/`fault_addr` are unchanged.
- R13: Interrupt and break entries leave `syndrome`, `fault_addr` and `btr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | AW | Program counter of the current instruction |
| cur_status | input | 8 | Current status register |
| in_dslot | input | 1 | Current instruction sits in a branch delay slot |
| in_imm | input | 1 | Current instruction carries an immediate prefix |
| br_imm | input | 1 | The branch owning the delay slot carried an immediate prefix |
| br_target | input | AW | Target of the pending branch |
| irq_req | input | 1 | External interrupt request |
| brk_req | input | 1 | Hardware break request |
| mmu_req | input | 1 | Translation fault request |
| mmu_miss | input | 1 | Fault kind: 1 miss, 0 protection |
| mmu_fetch | input | 1 | Faulting access was an instruction fetch |
| mmu_store | input | 1 | Faulting access was a store |
| mmu_addr | input | AW | Faulting translation address |
| unal_req | input | 1 | Unaligned data access exception request |
| unal_addr | input | AW | Unaligned access address |
| unal_det | input | 7 | Instruction-supplied syndrome detail |
| unal_det_vld | input | 1 | `unal_det` is valid |
| enter | output | 1 | One-cycle entry pulse, flush and register write enable |
| new_pc | output | AW | Vector address to fetch next |
| new_status | output | 8 | Status register after entry |
| rf_idx | output | 5 | Return-address register index |
| rf_data | output | AW | Return-address value |
| syndrome | output | 16 | Exception syndrome register |
| fault_addr | output | AW | Faulting address register |
| btr | output | AW | Saved branch target register |

## Verification
The hardest situations to reach are those where gating and priority interact. Examples are an interrupt that would be accepted but is masked by a delay slot, or a translation fault that arrives together with lower-priority requests while the branch carried a prefix. Random traffic rarely lines these up. The stimulus therefore sweeps every combination of the four requests, five gating status bits and three instruction-state flags. The remaining fault fields are derived from the sweep index. A second instance built without hardware exceptions receives the same stimulus, so that the ignored request is seen at its outputs.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int ST_W   = 8;
  localparam int ST_IE  = 1;
  localparam int ST_BIP = 2;
  localparam int ST_UM  = 3;
  localparam int ST_UMS = 4;
  localparam int ST_VM  = 5;
  localparam int ST_VMS = 6;
  localparam int ST_EIP = 7;

  localparam int SYN_W  = 16;
  localparam int CODE_W = 5;
  localparam int SYN_ST = 10;
  localparam int SYN_DS = 12;
  localparam int DET_LO = 5;
  localparam int DET_W  = 7;

  localparam int RF_IDX_W = 5;
  localparam logic [RF_IDX_W-1:0] RF_IRQ = 5'd14;
  localparam logic [RF_IDX_W-1:0] RF_BRK = 5'd16;
  localparam logic [RF_IDX_W-1:0] RF_EXC = 5'd17;

  localparam logic [7:0] OFS_IRQ = 8'h10;
  localparam logic [7:0] OFS_BRK = 8'h18;
  localparam logic [7:0] OFS_EXC = 8'h20;

  localparam logic [CODE_W-1:0] C_UNAL   = 5'd1;
  localparam logic [CODE_W-1:0] C_PROT_D = 5'd16;
  localparam logic [CODE_W-1:0] C_PROT_I = 5'd17;
  localparam logic [CODE_W-1:0] C_MISS_D = 5'd18;
  localparam logic [CODE_W-1:0] C_MISS_I = 5'd19;

  typedef enum logic [2:0] {
    CS_NONE = 3'd0,
    CS_IRQ  = 3'd1,
    CS_BRK  = 3'd2,
    CS_HWX  = 3'd3,
    CS_MMU  = 3'd4
  } cause_e;
endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
  import exc_entry_pkg::*;
#(
  parameter bit HAS_EXC = 1'b1
) (
  input  logic            irq_req,
  input  logic            brk_req,
  input  logic            hwx_req,
  input  logic            mmu_req,
  input  logic [ST_W-1:0] status,
  input  logic            in_dslot,
  input  logic            in_imm,
  output cause_e          cause
);
  logic irq_ok;
  logic hwx_ok;

  assign irq_ok = irq_req & status[ST_IE] & ~status[ST_EIP] & ~status[ST_BIP]
                  & ~in_dslot & ~in_imm;

  generate
    if (HAS_EXC) begin : g_hwx_on
      assign hwx_ok = hwx_req;
    end else begin : g_hwx_off
      assign hwx_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    if (mmu_req)      cause = CS_MMU;
    else if (hwx_ok)  cause = CS_HWX;
    else if (brk_req) cause = CS_BRK;
    else if (irq_ok)  cause = CS_IRQ;
    else              cause = CS_NONE;
  end
endmodule

// File: rtl/exc_ret_calc.sv
module exc_ret_calc
  import exc_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  cause_e                cause,
  input  logic [AW-1:0]         pc,
  input  logic                  in_dslot,
  input  logic                  in_imm,
  input  logic                  br_imm,
  output logic [RF_IDX_W-1:0]   idx,
  output logic [AW-1:0]         data,
  output logic [AW-1:0]         vec
);
  logic [3:0] rewind;

  always_comb begin
    if (in_dslot) rewind = br_imm ? 4'd8 : 4'd4;
    else          rewind = in_imm ? 4'd4 : 4'd0;
  end

  always_comb begin
    idx  = '0;
    data = pc;
    vec  = VEC_BASE;
    unique case (cause)
      CS_IRQ: begin
        idx = RF_IRQ;
        vec = VEC_BASE + AW'(OFS_IRQ);
      end
      CS_BRK: begin
        idx = RF_BRK;
        vec = VEC_BASE + AW'(OFS_BRK);
      end
      CS_HWX: begin
        idx  = RF_EXC;
        data = pc + AW'(4);
        vec  = VEC_BASE + AW'(OFS_EXC);
      end
      CS_MMU: begin
        idx  = RF_EXC;
        data = pc - AW'(rewind);
        vec  = VEC_BASE + AW'(OFS_EXC);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_status_upd.sv
module exc_status_upd
  import exc_entry_pkg::*;
(
  input  cause_e          cause,
  input  logic [ST_W-1:0] st_in,
  output logic [ST_W-1:0] st_out
);
  always_comb begin
    st_out         = st_in;
    st_out[ST_VMS] = st_in[ST_VM];
    st_out[ST_UMS] = st_in[ST_UM];
    st_out[ST_VM]  = 1'b0;
    st_out[ST_UM]  = 1'b0;
    unique case (cause)
      CS_IRQ:         st_out[ST_IE]  = 1'b0;
      CS_BRK:         st_out[ST_BIP] = 1'b1;
      CS_HWX, CS_MMU: st_out[ST_EIP] = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_syn_build.sv
module exc_syn_build
  import exc_entry_pkg::*;
(
  input  cause_e             cause,
  input  logic               in_dslot,
  input  logic               mmu_miss,
  input  logic               mmu_fetch,
  input  logic               mmu_store,
  input  logic [DET_W-1:0]   det,
  input  logic               det_vld,
  output logic [SYN_W-1:0]   syn
);
  always_comb begin
    syn = '0;
    if (cause == CS_MMU) begin
      if (mmu_miss) syn[CODE_W-1:0] = mmu_fetch ? C_MISS_I : C_MISS_D;
      else          syn[CODE_W-1:0] = mmu_fetch ? C_PROT_I : C_PROT_D;
      syn[SYN_ST] = mmu_store;
    end else begin
      syn[CODE_W-1:0] = C_UNAL;
      if (det_vld) syn[DET_LO +: DET_W] = det;
    end
    syn[SYN_DS] = in_dslot;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0,
  parameter bit HAS_EXC = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        cur_pc,
  input  logic [ST_W-1:0]      cur_status,
  input  logic                 in_dslot,
  input  logic                 in_imm,
  input  logic                 br_imm,
  input  logic [AW-1:0]        br_target,
  input  logic                 irq_req,
  input  logic                 brk_req,
  input  logic                 mmu_req,
  input  logic                 mmu_miss,
  input  logic                 mmu_fetch,
  input  logic                 mmu_store,
  input  logic [AW-1:0]        mmu_addr,
  input  logic                 unal_req,
  input  logic [AW-1:0]        unal_addr,
  input  logic [DET_W-1:0]     unal_det,
  input  logic                 unal_det_vld,
  output logic                 enter,
  output logic [AW-1:0]        new_pc,
  output logic [ST_W-1:0]      new_status,
  output logic [RF_IDX_W-1:0]  rf_idx,
  output logic [AW-1:0]        rf_data,
  output logic [SYN_W-1:0]     syndrome,
  output logic [AW-1:0]        fault_addr,
  output logic [AW-1:0]        btr
);
  cause_e                cause;
  logic [RF_IDX_W-1:0]   idx_d;
  logic [AW-1:0]         data_d;
  logic [AW-1:0]         vec_d;
  logic [ST_W-1:0]       st_d;
  logic [SYN_W-1:0]      syn_d;
  logic                  is_exc;

  exc_cause_arb #(.HAS_EXC(HAS_EXC)) u_arb (
    .irq_req  (irq_req),
    .brk_req  (brk_req),
    .hwx_req  (unal_req),
    .mmu_req  (mmu_req),
    .status   (cur_status),
    .in_dslot (in_dslot),
    .in_imm   (in_imm),
    .cause    (cause)
  );

  exc_ret_calc #(.AW(AW), .VEC_BASE(VEC_BASE)) u_ret (
    .cause    (cause),
    .pc       (cur_pc),
    .in_dslot (in_dslot),
    .in_imm   (in_imm),
    .br_imm   (br_imm),
    .idx      (idx_d),
    .data     (data_d),
    .vec      (vec_d)
  );

  exc_status_upd u_st (
    .cause  (cause),
    .st_in  (cur_status),
    .st_out (st_d)
  );

  exc_syn_build u_syn (
    .cause     (cause),
    .in_dslot  (in_dslot),
    .mmu_miss  (mmu_miss),
    .mmu_fetch (mmu_fetch),
    .mmu_store (mmu_store),
    .det       (unal_det),
    .det_vld   (unal_det_vld),
    .syn       (syn_d)
  );

  assign is_exc = (cause == CS_MMU) || (cause == CS_HWX);

  always_ff @(posedge clk) begin
    if (rst) begin
      enter      <= 1'b0;
      new_pc     <= '0;
      new_status <= '0;
      rf_idx     <= '0;
      rf_data    <= '0;
      syndrome   <= '0;
      fault_addr <= '0;
      btr        <= '0;
    end else begin
      enter <= (cause != CS_NONE);
      if (cause != CS_NONE) begin
        new_pc     <= vec_d;
        new_status <= st_d;
        rf_idx     <= idx_d;
        rf_data    <= data_d;
      end
      if (is_exc) begin
        syndrome   <= syn_d;
        fault_addr <= (cause == CS_MMU) ? mmu_addr : unal_addr;
        if (in_dslot) btr <= br_target;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input logic                clk,
  input logic                rst,
  input logic [ST_W-1:0]     cur_status,
  input logic                in_dslot,
  input logic                in_imm,
  input logic                irq_req,
  input logic                brk_req,
  input logic                mmu_req,
  input logic                unal_req,
  input logic                enter,
  input logic [AW-1:0]       new_pc,
  input logic [ST_W-1:0]     new_status,
  input logic [RF_IDX_W-1:0] rf_idx,
  input logic [SYN_W-1:0]    syndrome
);
  p_mode_clear_r5: assert property (@(posedge clk) disable iff (rst)
    enter |-> (!new_status[ST_VM] && !new_status[ST_UM]));

  p_mode_save_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(enter) |-> (new_status[ST_VMS] == $past(cur_status[ST_VM]) &&
                      new_status[ST_UMS] == $past(cur_status[ST_UM])));

  p_mmu_first_r2: assert property (@(posedge clk) disable iff (rst)
    mmu_req |=> (enter && rf_idx == RF_EXC && new_pc == VEC_BASE + AW'(OFS_EXC)));

  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!irq_req && !brk_req && !mmu_req && !unal_req) |=> !enter);

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (!mmu_req && !unal_req && !brk_req && irq_req &&
     (!cur_status[ST_IE] || in_dslot || in_imm)) |=> !enter);

  p_brk_vec_r4: assert property (@(posedge clk) disable iff (rst)
    (enter && rf_idx == RF_BRK) |-> (new_pc == VEC_BASE + AW'(OFS_BRK) && new_status[ST_BIP]));

  p_ds_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (mmu_req) |=> (syndrome[SYN_DS] == $past(in_dslot)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW), .VEC_BASE(VEC_BASE)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .cur_status (cur_status),
  .in_dslot   (in_dslot),
  .in_imm     (in_imm),
  .irq_req    (irq_req),
  .brk_req    (brk_req),
  .mmu_req    (mmu_req),
  .unal_req   (unal_req),
  .enter      (enter),
  .new_pc     (new_pc),
  .new_status (new_status),
  .rf_idx     (rf_idx),
  .syndrome   (syndrome)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
  localparam logic [31:0] BASE = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] cur_pc, br_target, mmu_addr, unal_addr;
  logic [7:0]  cur_status;
  logic in_dslot, in_imm, br_imm, irq_req, brk_req, mmu_req;
  logic mmu_miss, mmu_fetch, mmu_store, unal_req, unal_det_vld;
  logic [6:0] unal_det;

  logic        enter, enter_n;
  logic [31:0] new_pc, rf_data, fault_addr, btr;
  logic [31:0] new_pc_n, rf_data_n, fault_addr_n, btr_n;
  logic [7:0]  new_status, new_status_n;
  logic [4:0]  rf_idx, rf_idx_n;
  logic [15:0] syndrome, syndrome_n;

  exc_entry_ctrl #(.AW(32), .VEC_BASE(BASE), .HAS_EXC(1'b1)) i_exc_entry_ctrl (
    .clk, .rst, .cur_pc, .cur_status, .in_dslot, .in_imm, .br_imm, .br_target,
    .irq_req, .brk_req, .mmu_req, .mmu_miss, .mmu_fetch, .mmu_store, .mmu_addr,
    .unal_req, .unal_addr, .unal_det, .unal_det_vld,
    .enter, .new_pc, .new_status, .rf_idx, .rf_data, .syndrome, .fault_addr, .btr);

  exc_entry_ctrl #(.AW(32), .VEC_BASE(BASE), .HAS_EXC(1'b0)) i_exc_entry_ctrl_noexc (
    .clk, .rst, .cur_pc, .cur_status, .in_dslot, .in_imm, .br_imm, .br_target,
    .irq_req, .brk_req, .mmu_req, .mmu_miss, .mmu_fetch, .mmu_store, .mmu_addr,
    .unal_req, .unal_addr, .unal_det, .unal_det_vld,
    .enter(enter_n), .new_pc(new_pc_n), .new_status(new_status_n), .rf_idx(rf_idx_n),
    .rf_data(rf_data_n), .syndrome(syndrome_n), .fault_addr(fault_addr_n), .btr(btr_n));

  typedef struct packed {
    logic        en;
    logic [2:0]  cs;
    logic [31:0] pc;
    logic [7:0]  st;
    logic [4:0]  idx;
    logic [31:0] ra;
    logic [15:0] syn;
    logic [31:0] ear;
    logic [31:0] btr;
  } exp_t;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // cs: 0 none, 1 irq, 2 brk, 3 hw exception, 4 translation fault
  function automatic exp_t model(input bit hx, input exp_t prev);
    exp_t e;
    logic irq_ok;
    logic [31:0] rw;
    e = prev;
    irq_ok = irq_req && cur_status[1] && !cur_status[7] && !cur_status[2] && !in_dslot && !in_imm;
    if (mmu_req)              e.cs = 3'd4;
    else if (unal_req && hx)  e.cs = 3'd3;
    else if (brk_req)         e.cs = 3'd2;
    else if (irq_ok)          e.cs = 3'd1;
    else                      e.cs = 3'd0;
    e.en = (e.cs != 3'd0);
    if (e.en) begin
      e.st = (cur_status & ~8'h78) | ((cur_status & 8'h28) << 1);
      case (e.cs)
        3'd1: begin e.st[1] = 1'b0; e.pc = BASE + 32'h10; e.idx = 5'd14; e.ra = cur_pc; end
        3'd2: begin e.st[2] = 1'b1; e.pc = BASE + 32'h18; e.idx = 5'd16; e.ra = cur_pc; end
        3'd3: begin e.st[7] = 1'b1; e.pc = BASE + 32'h20; e.idx = 5'd17; e.ra = cur_pc + 32'd4; end
        default: begin
          e.st[7] = 1'b1; e.pc = BASE + 32'h20; e.idx = 5'd17;
          rw = in_dslot ? (br_imm ? 32'd8 : 32'd4) : (in_imm ? 32'd4 : 32'd0);
          e.ra = cur_pc - rw;
        end
      endcase
    end
    if (e.cs == 3'd4) begin
      e.syn = 16'(mmu_miss ? (mmu_fetch ? 19 : 18) : (mmu_fetch ? 17 : 16))
              | (16'(mmu_store) << 10) | (16'(in_dslot) << 12);
      e.ear = mmu_addr;
      if (in_dslot) e.btr = br_target;
    end else if (e.cs == 3'd3) begin
      e.syn = 16'd1 | (unal_det_vld ? (16'(unal_det) << 5) : 16'd0) | (16'(in_dslot) << 12);
      e.ear = unal_addr;
      if (in_dslot) e.btr = br_target;
    end
    return e;
  endfunction

  task automatic drive(input int i);
    logic [11:0] b;
    b = 12'(i);
    mmu_req    = b[0];
    unal_req   = b[1];
    brk_req    = b[2];
    irq_req    = b[3];
    cur_status = {b[5], b[3], b[8], b[1], b[7], b[6], b[4], b[2]};
    in_dslot   = b[9];
    in_imm     = b[10];
    br_imm     = b[11];
    mmu_miss   = b[0] ^ b[5];
    mmu_fetch  = b[1] ^ b[9];
    mmu_store  = b[6] ^ b[11];
    unal_det_vld = b[4] ^ b[10];
    unal_det   = b[10:4];
    cur_pc     = 32'h0000_2000 + (32'(i) << 3);
    br_target  = 32'h8000_0000 | (32'(i) << 2);
    mmu_addr   = 32'h4000_0000 + 32'(i);
    unal_addr  = 32'h6000_0001 + (32'(i) << 1);
  endtask

  initial begin
    exp_t m, mn;
    string rtag;
    string stag;
    drive(0);
    mmu_req = 0; unal_req = 0; brk_req = 0; irq_req = 0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 enter", 32'(enter), 0);
    chk("R1 new_pc", new_pc, 0);
    chk("R1 new_status", 32'(new_status), 0);
    chk("R1 rf_idx", 32'(rf_idx), 0);
    chk("R1 rf_data", rf_data, 0);
    chk("R1 syndrome", 32'(syndrome), 0);
    chk("R1 fault_addr", fault_addr, 0);
    chk("R1 btr", btr, 0);
    m = '0;
    mn = '0;
    rst = 1'b0;
    for (int i = 0; i < 4096; i++) begin
      drive(i);
      m  = model(1'b1, m);
      mn = model(1'b0, mn);
      @(negedge clk);
      chk((irq_req && !mmu_req && !unal_req && !brk_req) ? "R3 irq gate enter" : "R2 enter",
          32'(enter), 32'(m.en));
      if (m.en) begin
        chk("R4 new_pc", new_pc, m.pc);
        chk("R5 R6 status", 32'(new_status), 32'(m.st));
        rtag = (m.cs == 3'd4) ? "R8 rf" : "R7 rf";
        chk(rtag, {27'd0, rf_idx}, {27'd0, m.idx});
        chk(rtag, rf_data, m.ra);
      end
      stag = (m.cs == 3'd4) ? "R10 syndrome" : (m.cs == 3'd3) ? "R11 syndrome" : "R13 syndrome";
      chk(stag, 32'(syndrome), 32'(m.syn));
      chk("R9 dslot bit", 32'(syndrome[12]), 32'(m.syn[12]));
      chk((m.cs == 3'd4) ? "R10 fault_addr" : (m.cs == 3'd3) ? "R11 fault_addr" : "R13 fault_addr",
          fault_addr, m.ear);
      chk("R9 btr", btr, m.btr);
      chk("R12 enter", 32'(enter_n), 32'(mn.en));
      chk("R12 syndrome", 32'(syndrome_n), 32'(mn.syn));
      chk("R12 fault_addr", fault_addr_n, mn.ear);
      if (mn.en) chk("R12 rf_idx", 32'(rf_idx_n), 32'(mn.idx));
    end
    drive(0);
    mmu_req = 0; unal_req = 0; brk_req = 0; irq_req = 0;
    @(negedge clk);
    chk("R2 idle enter", 32'(enter), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule